// File: doc/BRIEF.md
# Sequenced Interval Endpoint Min/Max Reducer

This block finishes an interval multiplication. It receives the four cross products of two intervals' endpoints: lower×lower, lower×upper, upper×lower and upper×upper, called p, q, r and t. Each product is an IEEE-754 binary floating-point word, 64-bit double precision by default. The block returns the smallest product as the lower bound of the result interval and the largest as the upper bound. The products come from elsewhere.

A single floating-point ordering comparator is shared across a fixed schedule of five comparisons:
- p against q, which seeds both a running minimum and a running maximum.
- The running minimum against r, then against t. The second of these yields the lower bound.
- The running maximum against r, then against t. The second of these yields the upper bound.

A two-bit pick code steers the comparator's operands. Code 00 selects p and q. Code 01 selects the running value and r. Code 10 selects the running value and t. Because the schedule never depends on the data, every request takes the same number of cycles. The sign of any operand, or a zero crossing, does not change the latency, which makes the block easy to place in a pipeline.

A request is a one-cycle `start` pulse. The four operands are sampled in the same cycle as `start`. After the fixed latency, `done` pulses for one cycle, with both bound registers loaded.

Top module: `ivr_minmax_seq`

## Requirements
- R1: After synchronous reset, `zl` and `zu` are all zeros and `done` is low.
- R2: When no operand is NaN, `zl` equals the numerically least of p, q, r, t. Ordering is by sign first, then by the magnitude field (exponent and fraction bits taken together as an unsigned number). Infinities (exponent all ones, fraction zero) are the extremes.
- R3: When no operand is NaN, `zu` equals the numerically greatest of the four operands, using the same ordering as R2.
- R4: +0 and -0 compare equal. When several operands share the extreme value, the output carries the bit pattern of the earliest of them in the order p, q, r, t. This holds for both bounds.
- R5: If any operand is a NaN (exponent all ones, fraction nonzero), both `zl` and `zu` become the canonical quiet NaN: sign 0, exponent all ones, fraction MSB 1 and the other fraction bits 0.
- R6: `done` is high for exactly one cycle. It is high in the sixth cycle after the clock edge that accepted `start`, whatever the operand values.
- R7: A `start` that arrives while a request is in progress, including the cycle in which `done` is high, has no effect. It changes neither the result nor the number of `done` pulses.
- R8: The operands are captured on the accepting edge. Changing `p_in`..`t_in` afterwards does not alter the result.
- R9: `zl` and `zu` hold their values between requests. `zu` changes only on the edge that raises `done`.
- R10: Infinities take part in ordering as the largest and smallest values. -inf is reported as the lower bound and +inf as the upper bound.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request pulse; operands sampled with it |
| p_in | input | 1+EXP_W+FRAC_W | Product lower×lower |
| q_in | input | 1+EXP_W+FRAC_W | Product lower×upper |
| r_in | input | 1+EXP_W+FRAC_W | Product upper×lower |
| t_in | input | 1+EXP_W+FRAC_W | Product upper×upper |
| zl | output | 1+EXP_W+FRAC_W | Lower bound register |
| zu | output | 1+EXP_W+FRAC_W | Upper bound register |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with a 3-bit exponent and a 2-bit fraction. This gives a 6-bit word with only 64 encodings, so the bench sweeps every combination of p and q while r and t come from a pseudo-random sequence. Signed zeros, infinities, NaNs and ties between equal values therefore occur thousands of times across the comparison steps. The expected bounds come from a signed integer ordering key computed in the bench. Directed requests add start pulses while busy, operand changes after capture, and idle periods.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PQ    = 3'd1,
        ST_MIN_R = 3'd2,
        ST_MIN_T = 3'd3,
        ST_MAX_R = 3'd4,
        ST_MAX_T = 3'd5,
        ST_DONE  = 3'd6
    } ivr_state_e;

    // comparator operand pick codes
    typedef enum logic [1:0] {
        PICK_PQ = 2'b00,
        PICK_R  = 2'b01,
        PICK_T  = 2'b10
    } ivr_pick_e;

    typedef struct packed {
        logic      capture;
        ivr_pick_e pick;
        logic      use_max;
        logic      ld_pair;
        logic      ld_run;
        logic      ld_lo;
        logic      ld_hi;
    } ivr_ctl_t;

endpackage

// File: rtl/ivr_seq.sv
module ivr_seq
    import ivr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output ivr_state_e state,
    output ivr_ctl_t   ctl,
    output logic       done
);

    ivr_state_e nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt         = state;
        ctl         = '0;
        ctl.pick    = PICK_PQ;
        done        = 1'b0;
        case (state)
            ST_IDLE: begin
                if (start) begin
                    ctl.capture = 1'b1;
                    nxt         = ST_PQ;
                end
            end
            ST_PQ: begin
                ctl.pick    = PICK_PQ;
                ctl.ld_pair = 1'b1;
                nxt         = ST_MIN_R;
            end
            ST_MIN_R: begin
                ctl.pick   = PICK_R;
                ctl.ld_run = 1'b1;
                nxt        = ST_MIN_T;
            end
            ST_MIN_T: begin
                ctl.pick  = PICK_T;
                ctl.ld_lo = 1'b1;
                nxt       = ST_MAX_R;
            end
            ST_MAX_R: begin
                ctl.pick    = PICK_R;
                ctl.use_max = 1'b1;
                ctl.ld_run  = 1'b1;
                nxt         = ST_MAX_T;
            end
            ST_MAX_T: begin
                ctl.pick    = PICK_T;
                ctl.use_max = 1'b1;
                ctl.ld_hi   = 1'b1;
                nxt         = ST_DONE;
            end
            ST_DONE: begin
                done = 1'b1;
                nxt  = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/ivr_pick_mux.sv
module ivr_pick_mux
    import ivr_pkg::*;
#(
    parameter int W = 64
) (
    input  ivr_pick_e      pick,
    input  logic           use_max,
    input  logic [W-1:0]   p,
    input  logic [W-1:0]   q,
    input  logic [W-1:0]   r,
    input  logic [W-1:0]   t,
    input  logic [W-1:0]   run_min,
    input  logic [W-1:0]   run_max,
    output logic [W-1:0]   a,
    output logic [W-1:0]   b
);

    logic [W-1:0] run;

    assign run = use_max ? run_max : run_min;

    always_comb begin
        case (pick)
            PICK_R:  begin a = run; b = r; end
            PICK_T:  begin a = run; b = t; end
            default: begin a = p;   b = q; end
        endcase
    end

endmodule

// File: rtl/ivr_fp_cmp.sv
module ivr_fp_cmp #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] a,
    input  logic [EXP_W+FRAC_W:0] b,
    output logic                  b_lt,
    output logic                  b_gt,
    output logic                  any_nan
);

    localparam int W = 1 + EXP_W + FRAC_W;

    logic         sa, sb;
    logic [W-2:0] ma, mb;
    logic         nan_a, nan_b, both_zero;

    assign sa        = a[W-1];
    assign sb        = b[W-1];
    assign ma        = a[W-2:0];
    assign mb        = b[W-2:0];
    assign nan_a     = (&a[W-2:FRAC_W]) && (|a[FRAC_W-1:0]);
    assign nan_b     = (&b[W-2:FRAC_W]) && (|b[FRAC_W-1:0]);
    assign any_nan   = nan_a | nan_b;
    assign both_zero = (ma == '0) && (mb == '0);

    always_comb begin
        if (both_zero) begin
            b_lt = 1'b0;
            b_gt = 1'b0;
        end else if (sa != sb) begin
            b_lt = sb;
            b_gt = sa;
        end else if (!sa) begin
            b_lt = mb < ma;
            b_gt = mb > ma;
        end else begin
            b_lt = mb > ma;
            b_gt = mb < ma;
        end
    end

endmodule

// File: rtl/ivr_minmax_seq.sv
module ivr_minmax_seq
    import ivr_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [EXP_W+FRAC_W:0] p_in,
    input  logic [EXP_W+FRAC_W:0] q_in,
    input  logic [EXP_W+FRAC_W:0] r_in,
    input  logic [EXP_W+FRAC_W:0] t_in,
    output logic [EXP_W+FRAC_W:0] zl,
    output logic [EXP_W+FRAC_W:0] zu,
    output logic                  done
);

    localparam int W = 1 + EXP_W + FRAC_W;
    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic [W-1:0] p;
        logic [W-1:0] q;
        logic [W-1:0] r;
        logic [W-1:0] t;
    } quad_t;

    quad_t        ops;
    logic [W-1:0] run_min, run_max;
    logic         nan_seen;
    logic [W-1:0] cmp_a, cmp_b;
    logic         b_lt, b_gt, any_nan, nan_now;
    ivr_state_e   seq_state;
    ivr_ctl_t     ctl;

    ivr_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .state (seq_state),
        .ctl   (ctl),
        .done  (done)
    );

    ivr_pick_mux #(.W(W)) u_mux (
        .pick    (ctl.pick),
        .use_max (ctl.use_max),
        .p       (ops.p),
        .q       (ops.q),
        .r       (ops.r),
        .t       (ops.t),
        .run_min (run_min),
        .run_max (run_max),
        .a       (cmp_a),
        .b       (cmp_b)
    );

    ivr_fp_cmp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cmp (
        .a       (cmp_a),
        .b       (cmp_b),
        .b_lt    (b_lt),
        .b_gt    (b_gt),
        .any_nan (any_nan)
    );

    assign nan_now = nan_seen | any_nan;

    always_ff @(posedge clk) begin
        if (rst) begin
            ops      <= '0;
            run_min  <= '0;
            run_max  <= '0;
            nan_seen <= 1'b0;
            zl       <= '0;
            zu       <= '0;
        end else begin
            if (ctl.capture) begin
                ops      <= '{p: p_in, q: q_in, r: r_in, t: t_in};
                nan_seen <= 1'b0;
            end
            if (ctl.ld_pair | ctl.ld_run | ctl.ld_lo | ctl.ld_hi)
                nan_seen <= nan_now;
            if (ctl.ld_pair) begin
                run_min <= b_lt ? cmp_b : cmp_a;
                run_max <= b_gt ? cmp_b : cmp_a;
            end
            if (ctl.ld_run) begin
                if (ctl.use_max) begin
                    if (b_gt) run_max <= cmp_b;
                end else begin
                    if (b_lt) run_min <= cmp_b;
                end
            end
            if (ctl.ld_lo)
                zl <= nan_now ? QNAN : (b_lt ? cmp_b : run_min);
            if (ctl.ld_hi)
                zu <= nan_now ? QNAN : (b_gt ? cmp_b : run_max);
        end
    end

endmodule

// File: rtl/ivr_chk.sv
module ivr_chk
    import ivr_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic [EXP_W+FRAC_W:0] zl,
    input logic [EXP_W+FRAC_W:0] zu,
    input logic                  done,
    input ivr_state_e            seq_state
);

    localparam int W = 1 + EXP_W + FRAC_W;
    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    function automatic logic is_nan(input logic [W-1:0] v);
        return (&v[W-2:FRAC_W]) && (|v[FRAC_W-1:0]);
    endfunction

    function automatic logic signed [W:0] okey(input logic [W-1:0] v);
        logic signed [W:0] m;
        m = $signed({2'b00, v[W-2:0]});
        return v[W-1] ? -m : m;
    endfunction

    logic accept;
    assign accept = start && (seq_state == ST_IDLE);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> ##6 done);

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && seq_state != ST_IDLE) |=> (seq_state != ST_PQ));

    // R9
    zu_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(zu) |-> done);

    // R9
    zl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(zl) |-> ##2 done);

    // R3
    bound_order_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !is_nan(zl)) |-> (okey(zl) <= okey(zu)));

    // R5
    nan_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (done && is_nan(zl)) |-> (zl == QNAN && zu == QNAN));

endmodule

bind ivr_minmax_seq ivr_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .zl        (zl),
    .zu        (zu),
    .done      (done),
    .seq_state (seq_state)
);

// File: tb/sim_ivr_minmax_seq.sv
`timescale 1ns/1ps
module sim_ivr_minmax_seq;

    localparam int EXP_W  = 3;
    localparam int FRAC_W = 2;
    localparam int W      = 1 + EXP_W + FRAC_W;
    localparam logic [W-1:0] QNAN = 6'b011110;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] p_in = '0, q_in = '0, r_in = '0, t_in = '0;
    logic [W-1:0] zl, zu;
    logic         done;

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    ivr_minmax_seq #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u0 (
        .clk(clk), .rst(rst), .start(start),
        .p_in(p_in), .q_in(q_in), .r_in(r_in), .t_in(t_in),
        .zl(zl), .zu(zu), .done(done)
    );

    function automatic bit f_nan(input logic [W-1:0] v);
        return (v[4:2] == 3'b111) && (v[1:0] != 2'b00);
    endfunction

    function automatic int f_key(input logic [W-1:0] v);
        int m;
        m = int'(v[W-2:0]);
        return v[W-1] ? -m : m;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] c, input logic [W-1:0] d,
                          input string tag, input bit busy);
        logic [W-1:0] v [4];
        logic [W-1:0] emin, emax;
        bit nan_any;
        bit lat_ok;
        int lim;
        v[0] = a; v[1] = b; v[2] = c; v[3] = d;
        nan_any = 1'b0;
        emin = a; emax = a;
        for (int i = 0; i < 4; i++) begin
            if (f_nan(v[i])) nan_any = 1'b1;
            if (i > 0 && f_key(v[i]) < f_key(emin)) emin = v[i];
            if (i > 0 && f_key(v[i]) > f_key(emax)) emax = v[i];
        end
        if (nan_any) begin emin = QNAN; emax = QNAN; end
        lat_ok = 1'b1;
        lim = busy ? 14 : 7;
        @(negedge clk);
        p_in = a; q_in = b; r_in = c; t_in = d; start = 1'b1;
        for (int k = 1; k <= lim; k++) begin
            @(negedge clk);
            // R8: operands scrambled after capture
            if (k == 1) begin p_in = ~a; q_in = ~b; r_in = ~c; t_in = ~d; end
            // R7: extra starts while busy and in the done cycle
            start = busy && (k == 3 || k == 6);
            if (done !== (k == 6)) lat_ok = 1'b0;
            if (k == 6) begin
                chk({tag, nan_any ? " R5 zl" : " R2 zl"}, zl, emin);
                chk({tag, nan_any ? " R5 zu" : " R3 zu"}, zu, emax);
            end
        end
        start = 1'b0;
        chk("R6 done timing", {{(W-1){1'b0}}, lat_ok}, {{(W-1){1'b0}}, 1'b1});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL R6 watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] hold_l, hold_u;
        repeat (3) @(negedge clk);
        // R1
        chk("R1 reset zl", zl, '0);
        chk("R1 reset zu", zu, '0);
        chk("R1 reset done", {{(W-1){1'b0}}, done}, '0);
        rst = 1'b0;
        @(negedge clk);

        // R4: signed zeros and ties keep earliest pattern
        run_op(6'h20, 6'h00, 6'h00, 6'h20, "R4", 1'b0);
        run_op(6'h01, 6'h20, 6'h00, 6'h01, "R4", 1'b0);
        run_op(6'h05, 6'h05, 6'h25, 6'h25, "R4", 1'b0);
        // R10: infinities are extremes
        run_op(6'h1C, 6'h3C, 6'h05, 6'h25, "R10", 1'b0);
        run_op(6'h1B, 6'h1C, 6'h3B, 6'h00, "R10", 1'b0);
        // R5: single NaN in last slot, negative NaN in first
        run_op(6'h01, 6'h02, 6'h03, 6'h1D, "R5", 1'b0);
        run_op(6'h3F, 6'h02, 6'h03, 6'h04, "R5", 1'b0);
        // R7: starts while busy are dropped
        run_op(6'h09, 6'h2A, 6'h11, 6'h03, "R7", 1'b1);
        chk("R7 zl after ignored start", zl, 6'h2A);
        chk("R7 zu after ignored start", zu, 6'h11);
        // R8: captured operands
        run_op(6'h12, 6'h07, 6'h33, 6'h0E, "R8", 1'b0);

        // R9: outputs hold across idle cycles with moving inputs
        hold_l = zl; hold_u = zu;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            p_in = 6'(k * 7); q_in = 6'(k * 13); r_in = 6'(k * 3); t_in = 6'(k * 29);
        end
        chk("R9 zl held", zl, hold_l);
        chk("R9 zu held", zu, hold_u);

        // near-exhaustive sweep: all p,q pairs, pseudo-random r,t
        for (int i = 0; i < 4096; i++) begin
            logic [W-1:0] rr, tt;
            lfsr = step(lfsr); rr = lfsr[W-1:0];
            lfsr = step(lfsr); tt = lfsr[W+5:6];
            run_op(6'(i), 6'(i >> 6), rr, tt, "sweep", 1'b0);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule